// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Controller

This block sits inside a PCIe endpoint and turns internal interrupt events into memory-write requests. It holds a vector table with one entry per interrupt vector. Each entry has a 64-bit message address, a 32-bit message data word and a per-vector mask bit. It also holds a pending bit array. Software reaches both through a plain register write port and a combinational read port. Every event is first recorded in the pending array. A vector that is pending, unmasked and allowed to send by the global controls is turned into one request on the `req_*` output. The request carries the entry's address and data, and the data passes through unmodified because its low byte names the interrupt vector on the host side.

Events that arrive while a vector is masked, while the function mask is set or while sending is disabled stay pending. The block sends them later, with no help from software, once the blocking condition goes away. A pending bit merges any number of repeat events into a single message.

The output is a valid/ready stream with a single request slot. Once `req_valid` rises, `req_addr` and `req_data` hold steady until a cycle in which `req_ready` is high, and that cycle completes the transfer. The slot is then empty for at least one cycle. An event on an unmasked vector, with sending allowed and the slot free, raises `req_valid` two clock edges later: the first edge records it as pending and the second loads the slot.

Top module: `msgint_vector_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every pending bit is 0, every table field reads 0 and `req_valid` is 0.
- R2: Entry v starts at byte TABLE_BASE+16*v. Offset +0 holds the address low dword, +4 the address high dword, +8 the data and +12 the control word, whose bit 0 is the mask. The other bits of the control word read as 0. Each field reads back what was last written to it.
- R3: An event on an unmasked vector, with `msg_enable`=1 and `func_mask`=0, produces exactly one request with `req_addr`={high,low} and `req_data` equal to the stored data, bit for bit.
- R4: An event on a masked vector produces no request and sets that vector's pending bit.
- R5: Writing 0 to the mask of a pending vector produces exactly one request for it and clears its pending bit.
- R6: The pending array reads at PEND_BASE as 64-bit words, low dword first. Bit n of 64-bit word k is vector 64*k+n, and bits beyond the vector count read 0. Writes to this region change nothing.
- R7: Any number of events on a vector that is already pending yield a single message.
- R8: While `msg_enable`=0 or `func_mask`=1, no request is started and events only set pending bits. Removing the block sends all pending, unmasked vectors.
- R9: When several vectors are eligible at once, they are sent in ascending vector index.
- R10: A request holds `req_valid`, `req_addr` and `req_data` stable until `req_ready`. Only one request is outstanding at a time, and `req_valid` is low in the cycle after a transfer.
- R11: An event on a vector in the same cycle that vector is loaded into the request slot leaves it pending, so a second message follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_enable | input | 1 | Global send enable |
| func_mask | input | 1 | Function-wide mask; events only pend while high |
| evt | input | NUM_VEC | One event pulse per vector |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the dword accessed |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| req_valid | output | 1 | Memory-write request valid |
| req_ready | input | 1 | Consumer accepts the request |
| req_addr | output | 64 | Message address of the request |
| req_data | output | 32 | Message data of the request |

## Verification
The bench builds the block with 70 vectors, a 12-bit register address, the table at 0 and the pending array at 0x800. With 70 vectors the pending array spans two 64-bit words, and the second word is only partly filled. That brings into reach the rule that maps vectors to words, the reads of the upper dword and of bits beyond the vector count, and an index width that is not a power of two. Odd vectors get a non-zero high address dword, so both halves of the 64-bit address are checked on every message.

// File: rtl/msgint_pkg.sv
package msgint_pkg;
  localparam int DWORD_W = 32;

  typedef struct packed {
    logic [DWORD_W-1:0] addr_hi;
    logic [DWORD_W-1:0] addr_lo;
    logic [DWORD_W-1:0] data;
  } msg_entry_t;
endpackage

// File: rtl/msgint_table.sv
module msgint_table
  import msgint_pkg::*;
#(
  parameter int NUM_VEC    = 32,
  parameter int IDX_W      = 5,
  parameter int ADDR_W     = 16,
  parameter int TABLE_BASE = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic               rd_hit,
  output logic [31:0]        rd_data,
  output logic [NUM_VEC-1:0] mask_vec,
  input  logic [IDX_W-1:0]   sel_idx,
  output msg_entry_t         sel_entry
);
  localparam logic [31:0] T_LO = 32'(TABLE_BASE);
  localparam logic [31:0] T_HI = 32'(TABLE_BASE + 16 * NUM_VEC);

  logic [31:0] lo_q [NUM_VEC];
  logic [31:0] hi_q [NUM_VEC];
  logic [31:0] dat_q[NUM_VEC];
  logic [NUM_VEC-1:0] mask_q;

  logic [31:0]      a32, off;
  logic [IDX_W-1:0] idx;
  logic [1:0]       fld;
  logic             unused_tbl;

  assign a32        = 32'(addr);
  assign off        = a32 - T_LO;
  assign idx        = off[IDX_W+3:4];
  assign fld        = off[3:2];
  assign rd_hit     = (a32 >= T_LO) && (a32 < T_HI);
  assign unused_tbl = ^{off[31:IDX_W+4], off[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        lo_q[v]  <= '0;
        hi_q[v]  <= '0;
        dat_q[v] <= '0;
      end
      mask_q <= '1;
    end else if (wr_en && rd_hit) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        if (idx == IDX_W'(v)) begin
          case (fld)
            2'd0:    lo_q[v]   <= wdata;
            2'd1:    hi_q[v]   <= wdata;
            2'd2:    dat_q[v]  <= wdata;
            default: mask_q[v] <= wdata[0];
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit) begin
      case (fld)
        2'd0:    rd_data = lo_q[idx];
        2'd1:    rd_data = hi_q[idx];
        2'd2:    rd_data = dat_q[idx];
        default: rd_data = {31'd0, mask_q[idx]};
      endcase
    end
  end

  assign mask_vec  = mask_q;
  assign sel_entry = '{addr_hi: hi_q[sel_idx], addr_lo: lo_q[sel_idx], data: dat_q[sel_idx]};
endmodule

// File: rtl/msgint_pending.sv
module msgint_pending #(
  parameter int NUM_VEC   = 32,
  parameter int ADDR_W    = 16,
  parameter int PEND_BASE = 'h2000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] evt,
  input  logic [NUM_VEC-1:0] clr,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_VEC-1:0] pend_vec,
  output logic               rd_hit,
  output logic [31:0]        rd_data
);
  localparam int QWORDS = (NUM_VEC + 63) / 64;
  localparam int DWORDS = 2 * QWORDS;
  localparam int PAD_W  = 32 * DWORDS;
  localparam int DWI_W  = $clog2(DWORDS);
  localparam logic [31:0] P_LO = 32'(PEND_BASE);
  localparam logic [31:0] P_HI = 32'(PEND_BASE + 4 * DWORDS);

  logic [NUM_VEC-1:0] pend_q;
  logic [PAD_W-1:0]   pend_pad;
  logic [31:0]        a32, off;
  logic [DWI_W-1:0]   dw_idx;
  logic               unused_pnd;

  // a new event wins over the clear of a launch in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | evt;
  end

  assign a32        = 32'(addr);
  assign off        = a32 - P_LO;
  assign dw_idx     = off[DWI_W+1:2];
  assign rd_hit     = (a32 >= P_LO) && (a32 < P_HI);
  assign pend_pad   = PAD_W'(pend_q);
  assign rd_data    = rd_hit ? pend_pad[{dw_idx, 5'd0} +: 32] : 32'd0;
  assign pend_vec   = pend_q;
  assign unused_pnd = ^{off[31:DWI_W+2], off[1:0]};
endmodule

// File: rtl/msgint_arb.sv
module msgint_arb #(
  parameter int NUM_VEC = 32,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_VEC-1:0] elig,
  output logic               gnt_valid,
  output logic [IDX_W-1:0]   gnt_idx,
  output logic [NUM_VEC-1:0] gnt_onehot
);
  always_comb begin
    gnt_idx = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (elig[v]) gnt_idx = IDX_W'(v);
    end
  end

  assign gnt_valid  = |elig;
  assign gnt_onehot = elig & (~elig + NUM_VEC'(1));
endmodule

// File: rtl/msgint_vector_ctrl.sv
module msgint_vector_ctrl
  import msgint_pkg::*;
#(
  parameter int NUM_VEC    = 32,
  parameter int ADDR_W     = 16,
  parameter int TABLE_BASE = 0,
  parameter int PEND_BASE  = 'h2000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_enable,
  input  logic               func_mask,
  input  logic [NUM_VEC-1:0] evt,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [63:0]        req_addr,
  output logic [31:0]        req_data
);
  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [NUM_VEC-1:0] mask_vec, pend_vec, elig, gnt_onehot;
  logic               gnt_valid, send_ok, tbl_hit, pnd_hit;
  logic [IDX_W-1:0]   gnt_idx;
  logic [31:0]        tbl_rd, pnd_rd;
  msg_entry_t         sel_entry;

  msgint_table #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .TABLE_BASE(TABLE_BASE)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .rd_hit(tbl_hit), .rd_data(tbl_rd), .mask_vec(mask_vec),
    .sel_idx(gnt_idx), .sel_entry(sel_entry)
  );

  msgint_pending #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .PEND_BASE(PEND_BASE)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(gnt_onehot), .addr(reg_addr),
    .pend_vec(pend_vec), .rd_hit(pnd_hit), .rd_data(pnd_rd)
  );

  assign send_ok = msg_enable & ~func_mask & ~req_valid;
  assign elig    = pend_vec & ~mask_vec & {NUM_VEC{send_ok}};

  msgint_arb #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_arb (
    .elig(elig), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_onehot(gnt_onehot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_data  <= '0;
    end else if (req_valid && req_ready) begin
      req_valid <= 1'b0;
    end else if (gnt_valid) begin
      req_valid <= 1'b1;
      req_addr  <= {sel_entry.addr_hi, sel_entry.addr_lo};
      req_data  <= sel_entry.data;
    end
  end

  assign reg_rdata = tbl_hit ? tbl_rd : (pnd_hit ? pnd_rd : 32'd0);
endmodule

// File: rtl/msgint_checker.sv
module msgint_checker #(
  parameter int NUM_VEC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_enable,
  input logic               func_mask,
  input logic [NUM_VEC-1:0] evt,
  input logic               req_valid,
  input logic               req_ready,
  input logic [63:0]        req_addr,
  input logic [31:0]        req_data,
  input logic [NUM_VEC-1:0] pend_vec,
  input logic               gnt_valid
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data)); // R10

  AST_GAP_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid); // R10

  AST_SEND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && (!msg_enable || func_mask) |=> !req_valid); // R8

  AST_GRANT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> req_valid); // R3

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_evt
    AST_EVT_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> pend_vec[i]); // R11
  end
endmodule

bind msgint_vector_ctrl msgint_checker #(.NUM_VEC(NUM_VEC)) u_chk (.*);

// File: tb/tb_msgint_vector_ctrl.sv
`timescale 1ns/1ps
module tb_msgint_vector_ctrl;
  localparam int NV = 70;
  localparam int PB = 'h800;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          en = 1'b0, fm = 1'b0, wr = 1'b0, ready = 1'b0;
  logic [NV-1:0] evt = '0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic          req_valid;
  logic [63:0]   req_addr;
  logic [31:0]   req_data;

  int checks = 0, failures = 0;
  logic [95:0] log_q[$];

  // behavioural reference state
  bit          m_mask[NV];
  bit          m_pend[NV];
  logic [31:0] m_lo[NV], m_hi[NV], m_dat[NV];
  bit          m_valid = 0;
  logic [63:0] m_addr = '0;
  logic [31:0] m_data = '0;

  always #2 clk = ~clk;

  msgint_vector_ctrl #(.NUM_VEC(NV), .ADDR_W(12), .TABLE_BASE(0), .PEND_BASE(PB)) dut (
    .clk(clk), .rst_n(rst_n), .msg_enable(en), .func_mask(fm), .evt(evt),
    .reg_wr_en(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .req_valid(req_valid), .req_ready(ready), .req_addr(req_addr), .req_data(req_data)
  );

  task automatic model_reset();
    for (int v = 0; v < NV; v++) begin
      m_mask[v] = 1; m_pend[v] = 0; m_lo[v] = '0; m_hi[v] = '0; m_dat[v] = '0;
    end
    m_valid = 0; m_addr = '0; m_data = '0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      int g;
      int a;
      if (req_valid && ready) log_q.push_back({req_addr, req_data});
      g = -1;
      if (!m_valid && en && !fm)
        for (int v = 0; v < NV; v++) if (g < 0 && m_pend[v] && !m_mask[v]) g = v;
      if (m_valid && ready) m_valid = 0;
      else if (g >= 0) begin
        m_valid = 1; m_addr = {m_hi[g], m_lo[g]}; m_data = m_dat[g];
      end
      if (g >= 0) m_pend[g] = 0;
      for (int v = 0; v < NV; v++) if (evt[v]) m_pend[v] = 1;
      a = int'(addr);
      if (wr && a < 16 * NV) begin
        case ((a / 4) % 4)
          0: m_lo[a / 16] = wdata;
          1: m_hi[a / 16] = wdata;
          2: m_dat[a / 16] = wdata;
          default: m_mask[a / 16] = wdata[0];
        endcase
      end
    end
  end

  function automatic logic [31:0] mread(int a);
    logic [31:0] r = '0;
    if (a < 16 * NV) begin
      case ((a / 4) % 4)
        0: r = m_lo[a / 16];
        1: r = m_hi[a / 16];
        2: r = m_dat[a / 16];
        default: r = {31'd0, m_mask[a / 16]};
      endcase
    end else if (a >= PB && a < PB + 16) begin
      for (int b = 0; b < 32; b++)
        if (((a - PB) / 4) * 32 + b < NV) r[b] = m_pend[((a - PB) / 4) * 32 + b];
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      chk(req_valid == m_valid, "R10", "cycle req_valid", 96'(req_valid), 96'(m_valid));
      if (m_valid)
        chk({req_addr, req_data} == {m_addr, m_data}, "R3", "cycle request", {req_addr, req_data}, {m_addr, m_data});
      chk(rdata == mread(int'(addr)), "R6", "cycle read data", 96'(rdata), 96'(mread(int'(addr))));
    end
  endtask

  task automatic wr_reg(int a, logic [31:0] d);
    wr = 1; addr = 12'(a); wdata = d; tick(); wr = 0;
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string req);
    addr = 12'(a); #1;
    chk(rdata == exp, req, "register read", 96'(rdata), 96'(exp));
  endtask

  task automatic pulse(int v);
    evt[v] = 1'b1; tick(); evt = '0;
  endtask

  function automatic logic [95:0] exp_msg(int v);
    return {32'(v & 1), 32'hFEE0_0000 + 32'(v * 16), 32'hC0DE_0000 | 32'(v)};
  endfunction

  task automatic log_chk(int v, string req);
    logic [95:0] got = '0;
    if (log_q.size() > 0) got = log_q.pop_front();
    chk(got == exp_msg(v), req, "message content/order", got, exp_msg(v));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    run(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(req_valid == 1'b0, "R1", "req_valid after reset", 96'(req_valid), 96'(0));
    rd_chk(12, 32'd1, "R1");
    rd_chk(69 * 16 + 12, 32'd1, "R1");
    rd_chk(69 * 16 + 8, 32'd0, "R1");
    rd_chk(PB + 8, 32'd0, "R1");

    // R2 program table
    for (int v = 0; v < NV; v++) begin
      wr_reg(v * 16, 32'hFEE0_0000 + 32'(v * 16));
      wr_reg(v * 16 + 4, 32'(v & 1));
      wr_reg(v * 16 + 8, 32'hC0DE_0000 | 32'(v));
    end
    rd_chk(5 * 16, 32'hFEE0_0050, "R2");
    rd_chk(5 * 16 + 4, 32'd1, "R2");
    rd_chk(5 * 16 + 8, 32'hC0DE_0005, "R2");
    rd_chk(5 * 16 + 12, 32'd1, "R2");

    en = 1; ready = 1;
    // R4 / R7 masked events pend, merged
    pulse(3); run(2); pulse(3); pulse(3); run(4);
    chk(log_q.size() == 0, "R4", "no message while masked", 96'(log_q.size()), 96'(0));
    rd_chk(PB, 32'h8, "R4");
    // R5 unmask releases exactly one message
    wr_reg(3 * 16 + 12, 32'd0); run(6);
    chk(log_q.size() == 1, "R7", "one message for merged events", 96'(log_q.size()), 96'(1));
    log_chk(3, "R5");
    rd_chk(PB, 32'h0, "R5");

    // R3 unmasked event
    pulse(3); run(5);
    chk(log_q.size() == 1, "R3", "one message per event", 96'(log_q.size()), 96'(1));
    log_chk(3, "R3");

    // R6 pending layout beyond 64 and ignored writes
    pulse(66); run(2);
    rd_chk(PB + 8, 32'h4, "R6");
    rd_chk(PB + 4, 32'h0, "R6");
    rd_chk(PB + 12, 32'h0, "R6");
    wr_reg(PB, 32'hFFFF_FFFF); wr_reg(PB + 8, 32'h0);
    rd_chk(PB, 32'h0, "R6");
    rd_chk(PB + 8, 32'h4, "R6");

    // R8 function mask, R9 ascending order
    fm = 1;
    wr_reg(66 * 16 + 12, 0); wr_reg(20 * 16 + 12, 0); wr_reg(10 * 16 + 12, 0);
    evt[20] = 1; evt[10] = 1; tick(); evt = '0; run(4);
    chk(log_q.size() == 0, "R8", "no message under function mask", 96'(log_q.size()), 96'(0));
    fm = 0; run(10);
    chk(log_q.size() == 3, "R9", "released count", 96'(log_q.size()), 96'(3));
    log_chk(10, "R9"); log_chk(20, "R9"); log_chk(66, "R9");

    // R8 global enable
    en = 0; pulse(10); run(4);
    chk(log_q.size() == 0, "R8", "no message while disabled", 96'(log_q.size()), 96'(0));
    en = 1; run(4);
    log_chk(10, "R8");

    // R10 back-pressure
    ready = 0; pulse(20); run(6);
    chk(req_valid == 1'b1 && req_data == 32'hC0DE_0014, "R10", "held request", 96'(req_data), 96'h14);
    chk(log_q.size() == 0, "R10", "no transfer without ready", 96'(log_q.size()), 96'(0));
    ready = 1; run(4);
    chk(log_q.size() == 1, "R10", "single transfer", 96'(log_q.size()), 96'(1));
    log_chk(20, "R10");

    // R11 event during its own launch
    pulse(20); pulse(20); run(6);
    chk(log_q.size() == 2, "R11", "second message after launch-cycle event", 96'(log_q.size()), 96'(2));
    log_chk(20, "R11"); log_chk(20, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule